// File: doc/BRIEF.md
# Half-Width Interval Timer

This block is a single 16-bit timer channel driven through a small register port. Software selects a count direction and a run mode, then enables the channel. The two run modes are single-shot, which stops at the first timeout, and free-running periodic. When the channel counts down, it starts at the interval-load value and falls to zero. When it counts up, it climbs from zero to the interval-load value. In both directions, reaching the end point restarts the count and raises a timeout flag. An 8-bit prescaler slows the count by a factor of prescale+1, but only when counting down. This stretches the reach of the timer to 24 bits.

A comparator raises a second flag when the running count equals a match register. The two flags are sticky raw status bits. A mask register selects which raw bits drive the single interrupt line. Software clears a flag by writing a one to its bit through a dedicated clear select. Software can also read the current count at any time, and can overwrite it.

Top module: `interval_timer16`

## Requirements
- R1: Register selects, used for both write and read: 0 control, 1 interval load, 2 prescale, 3 match, 4 count value, 5 mask, 6 clear on write and masked status on read, 7 raw status on read (a write to 7 is ignored). The control word places the enable at bit 0, the mode at bits 2:1 (01 single-shot, 10 periodic, 00 and 11 idle) and the direction at bit 3 (1 up, 0 down). In the raw, mask and clear words, the timeout flag is bit 0 and the match flag is bit 4.
- R2: After reset, control reads 0 (disabled, idle mode, count down), interval load reads 0xFFFF, the count reads 0xFFFF, prescale, match, mask and both flags read 0, and irq is low.
- R3: When counting down from a value L with prescale P and the prescaler phase at zero, the count steps once every P+1 cycles. On the step after 0 it reloads L and sets the timeout flag. That flag is first seen (L+1)(P+1) cycles after the enable write.
- R4: When counting up, the count steps every cycle whatever the prescale value. Starting from 0, it returns to 0 after reaching L and sets the timeout flag L+1 cycles after the enable write.
- R5: In single-shot mode, the timeout clears the enable bit. The count then rests at the load value (down) or at 0 (up).
- R6: In periodic mode, the enable bit stays set and counting continues through every timeout.
- R7: When the mode field is 00 or 11, an enabled channel does not count and sets no flag.
- R8: While the enable bit is low, the count and the prescaler phase hold. Re-enabling resumes the count from where it stopped.
- R9: A write to the count value select loads the count at that clock edge and restarts the prescaler phase.
- R10: The match flag is set one cycle after the enabled count equals the match register.
- R11: Raw flags are set whatever the mask holds. irq is the OR of raw AND mask, and select 6 reads raw AND mask.
- R12: Writing a one to a bit through the clear select clears that raw flag. If the flag's set event falls in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 16 | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 16 | Read data, combinational from rd_sel |
| count | output | 16 | Current count |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach from the ports is a clear write that lands on the same edge as a fresh timeout. Without care, the set-over-clear priority would never be tested. The bench runs a periodic count-down with a known period from a known start. Because the timeout edges are then exactly predictable, it times a clear write onto the second timeout edge and another clear onto the following edge. The second key case is a pause mid-prescale. The bench disables the channel between prescaler ticks and re-enables it later. Only a held prescaler phase gives the predicted remaining cycle count.

// File: rtl/ht_pkg.sv
// Shared definitions for the half-width interval timer: register select
// codes, run-mode encoding, control word layout and status flag positions.
package ht_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE     = 2'b00,
        MODE_ONESHOT  = 2'b01,
        MODE_PERIODIC = 2'b10,
        MODE_CAPTURE  = 2'b11
    } tmode_e;

    // Control word: bit 3 direction (1 = up), bits 2:1 mode, bit 0 enable.
    typedef struct packed {
        logic   up;
        tmode_e mode;
        logic   en;
    } ctrl_t;

    localparam int CTRL_W = 4;

    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_LOAD  = 3'd1;
    localparam logic [2:0] SEL_PRESC = 3'd2;
    localparam logic [2:0] SEL_MATCH = 3'd3;
    localparam logic [2:0] SEL_COUNT = 3'd4;
    localparam logic [2:0] SEL_MASK  = 3'd5;
    localparam logic [2:0] SEL_CLEAR = 3'd6;
    localparam logic [2:0] SEL_RAW   = 3'd7;

    localparam int STAT_W       = 8;
    localparam int FLAG_TIMEOUT = 0;
    localparam int FLAG_MATCH   = 4;
endpackage

// File: rtl/ht_prescaler.sv
// Prescaler for the interval timer. In count-down operation it produces one
// count step every limit+1 cycles. In count-up operation it steps every
// cycle and its phase stays put.
// Assumes: restart has priority over everything and zeroes the phase.
module ht_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             up,
    input  logic             restart,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] phase;
    logic             wrap_phase;

    assign wrap_phase = (phase >= limit);
    assign tick       = run && (up || wrap_phase);

    // Advance the divider phase while running down; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (run && !up) begin
            phase <= wrap_phase ? '0 : phase + 1'b1;
        end
    end

    // R8: a stopped channel keeps its divider phase.
    p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(phase));

    // R3: a down step is preceded by limit idle cycles, so phase restarts.
    p_phase_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !up && tick && !restart) |=> (phase == '0));
endmodule

// File: rtl/ht_counter.sv
// Count register of the interval timer. It moves one step per tick, either
// down to zero with a reload of the load value or up to the load value with
// a return to zero. It flags the wrap and compares against the match value.
// Assumes: a value write overrides any tick in the same cycle.
module ht_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             up,
    input  logic [CNT_W-1:0] load,
    input  logic             wr_val,
    input  logic [CNT_W-1:0] val_data,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap,
    output logic             hit
);
    logic at_end;

    assign at_end = up ? (count == load) : (count == '0);
    assign wrap   = tick && !wr_val && at_end;
    assign hit    = run && (count == match_val);

    // Update the count: value writes first, then wrap or single step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '1;
        end else if (wr_val) begin
            count <= val_data;
        end else if (tick) begin
            if (at_end) begin
                count <= up ? '0 : load;
            end else begin
                count <= up ? count + 1'b1 : count - 1'b1;
            end
        end
    end

    // R3: a down step lowers the count by one away from zero.
    p_down_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !up && !wr_val && count != '0) |=> (count == $past(count) - 1'b1));

    // R3: the down wrap reloads the load value.
    p_down_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !up) |=> (count == $past(load)));

    // R4: an up step raises the count by one below the load value.
    p_up_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && up && !wr_val && count != load) |=> (count == $past(count) + 1'b1));

    // R9: a value write lands at its own edge.
    p_value_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_val |=> (count == $past(val_data)));

    // R7, R8: no tick and no write means no change.
    p_no_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_val) |=> $stable(count));
endmodule

// File: rtl/ht_status.sv
// Sticky status flags with mask and write-one clear. Each bit is set by its
// event, cleared by a one in the clear vector, and set wins a tie. The
// interrupt is the OR of the masked flags.
// Assumes: the mask is written as a whole word.
module ht_status #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set,
    input  logic [STAT_W-1:0] clr,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_d,
    output logic [STAT_W-1:0] raw,
    output logic [STAT_W-1:0] mask,
    output logic [STAT_W-1:0] masked,
    output logic              irq
);
    assign masked = raw & mask;
    assign irq    = |masked;

    // Hold the interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (mask_we) begin
            mask <= mask_d;
        end
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_flag
        // One sticky flag: set beats clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw[i] <= 1'b0;
            end else if (set[i]) begin
                raw[i] <= 1'b1;
            end else if (clr[i]) begin
                raw[i] <= 1'b0;
            end
        end

        // R12: a set event always leaves the flag high, clear or not.
        p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> raw[i]);

        // R12: a lone clear drops the flag.
        p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !raw[i]);

        // R11: the mask has no say in whether a flag is recorded.
        p_unmasked_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (set[i] && !mask[i]) |=> raw[i]);
    end
endmodule

// File: rtl/interval_timer16.sv
// Half-width interval timer: register port, control word, prescaler, count
// register and status flags. A single-shot timeout clears the enable bit.
// Assumes: rd_data is combinational from rd_sel; writes act at the clock edge
// on which wr_en is high; a control write beats the single-shot auto-clear.
module interval_timer16
    import ht_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    localparam int CTRL_PAD = CNT_W - CTRL_W;
    localparam int STAT_PAD = CNT_W - STAT_W;
    localparam int PRE_PAD  = CNT_W - PRE_W;

    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  load_q;
    logic [PRE_W-1:0]  presc_q;
    logic [CNT_W-1:0]  match_q;

    logic ctrl_we, load_we, presc_we, match_we, val_we, mask_we, clr_we;
    logic run, tick, wrap, hit;
    logic [STAT_W-1:0] flag_set, flag_clr, raw, mask, masked;

    assign ctrl_we  = wr_en && (wr_sel == SEL_CTRL);
    assign load_we  = wr_en && (wr_sel == SEL_LOAD);
    assign presc_we = wr_en && (wr_sel == SEL_PRESC);
    assign match_we = wr_en && (wr_sel == SEL_MATCH);
    assign val_we   = wr_en && (wr_sel == SEL_COUNT);
    assign mask_we  = wr_en && (wr_sel == SEL_MASK);
    assign clr_we   = wr_en && (wr_sel == SEL_CLEAR);

    assign run = ctrl_q.en &&
                 ((ctrl_q.mode == MODE_ONESHOT) || (ctrl_q.mode == MODE_PERIODIC));

    // Control word: software writes, single-shot timeout drops enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end else if (wrap && ctrl_q.mode == MODE_ONESHOT) begin
            ctrl_q.en <= 1'b0;
        end
    end

    // Configuration registers written straight from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= '1;
            presc_q <= '0;
            match_q <= '0;
        end else begin
            if (load_we)  load_q  <= wr_data;
            if (presc_we) presc_q <= wr_data[PRE_W-1:0];
            if (match_we) match_q <= wr_data;
        end
    end

    ht_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .up      (ctrl_q.up),
        .restart (val_we),
        .limit   (presc_q),
        .tick    (tick)
    );

    ht_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick),
        .up        (ctrl_q.up),
        .load      (load_q),
        .wr_val    (val_we),
        .val_data  (wr_data),
        .match_val (match_q),
        .count     (count),
        .wrap      (wrap),
        .hit       (hit)
    );

    // Route the events and clear word to their flag positions.
    always_comb begin
        flag_set               = '0;
        flag_set[FLAG_TIMEOUT] = wrap;
        flag_set[FLAG_MATCH]   = hit;
        flag_clr               = clr_we ? wr_data[STAT_W-1:0] : '0;
    end

    ht_status #(.STAT_W(STAT_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (flag_set),
        .clr     (flag_clr),
        .mask_we (mask_we),
        .mask_d  (wr_data[STAT_W-1:0]),
        .raw     (raw),
        .mask    (mask),
        .masked  (masked),
        .irq     (irq)
    );

    // Read multiplexer over the register selects.
    always_comb begin
        case (rd_sel)
            SEL_CTRL:  rd_data = {{CTRL_PAD{1'b0}}, ctrl_q};
            SEL_LOAD:  rd_data = load_q;
            SEL_PRESC: rd_data = {{PRE_PAD{1'b0}}, presc_q};
            SEL_MATCH: rd_data = match_q;
            SEL_COUNT: rd_data = count;
            SEL_MASK:  rd_data = {{STAT_PAD{1'b0}}, mask};
            SEL_CLEAR: rd_data = {{STAT_PAD{1'b0}}, masked};
            default:   rd_data = {{STAT_PAD{1'b0}}, raw};
        endcase
    end

    // R5: a single-shot timeout stops the channel.
    p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ctrl_q.mode == MODE_ONESHOT && !ctrl_we) |=> !ctrl_q.en);

    // R6: a periodic timeout keeps the channel running.
    p_periodic_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ctrl_q.mode == MODE_PERIODIC && !ctrl_we) |=> ctrl_q.en);

    // R10: an enabled count equal to match records the match flag.
    p_match_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count == match_q) |=> raw[FLAG_MATCH]);

    // R7: idle modes never produce a timeout.
    p_idle_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode == MODE_IDLE || ctrl_q.mode == MODE_CAPTURE) |-> !wrap);
endmodule

// File: tb/interval_timer16_tb.sv
`timescale 1ns/1ps
module interval_timer16_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic [15:0] count;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    interval_timer16 u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .count(count), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [15:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    // Cycles until a raw flag bit is first seen high; 9999 if never.
    task automatic measure(input int bitpos, input int limit, output int n);
        logic [15:0] v;
        n = 9999;
        for (int i = 1; i <= limit; i++) begin
            step();
            rd(3'd7, v);
            if (v[bitpos]) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic prep(input logic [15:0] ld, input logic [15:0] ps, input logic [15:0] start);
        wr(3'd0, 16'h0);
        wr(3'd1, ld);
        wr(3'd2, ps);
        wr(3'd6, 16'h00FF);
        wr(3'd4, start);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int n;
        int lv[4] = '{0, 1, 2, 5};
        int pv[3] = '{0, 1, 3};
        int uv[4] = '{0, 1, 4, 7};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R2 / R1: reset values through each select
        rd(3'd0, v); chk(v == 16'h0, "R2 ctrl", v, 0);
        rd(3'd1, v); chk(v == 16'hFFFF, "R2 load", v, 16'hFFFF);
        rd(3'd2, v); chk(v == 16'h0, "R2 prescale", v, 0);
        rd(3'd3, v); chk(v == 16'h0, "R2 match", v, 0);
        rd(3'd4, v); chk(v == 16'hFFFF, "R2 count read", v, 16'hFFFF);
        chk(count == 16'hFFFF, "R2 count port", count, 16'hFFFF);
        rd(3'd5, v); chk(v == 16'h0, "R2 mask", v, 0);
        rd(3'd7, v); chk(v == 16'h0, "R2 raw", v, 0);
        chk(irq == 1'b0, "R2 irq", irq, 0);

        // R9: value write lands at its edge; R1 select 7 write ignored
        wr(3'd4, 16'h1234);
        chk(count == 16'h1234, "R9 value load", count, 16'h1234);
        wr(3'd7, 16'h00FF);
        rd(3'd7, v); chk(v == 16'h0, "R1 raw write ignored", v, 0);

        // R3 / R5: count-down single-shot sweep
        foreach (lv[a]) begin
            foreach (pv[b]) begin
                prep(16'(lv[a]), 16'(pv[b]), 16'(lv[a]));
                wr(3'd0, 16'h0003);
                measure(0, 400, n);
                chk(n == (lv[a] + 1) * (pv[b] + 1), "R3 down period", n, (lv[a] + 1) * (pv[b] + 1));
                rd(3'd0, v); chk(v[0] == 1'b0, "R5 enable cleared", v[0], 0);
                step(); step();
                chk(count == 16'(lv[a]), "R5 rests at load", count, lv[a]);
            end
        end

        // R4 / R5: count-up single-shot sweep with prescale 3 ignored
        foreach (uv[a]) begin
            prep(16'(uv[a]), 16'd3, 16'd0);
            wr(3'd0, 16'h000B);
            measure(0, 400, n);
            chk(n == uv[a] + 1, "R4 up period", n, uv[a] + 1);
            rd(3'd0, v); chk(v[0] == 1'b0, "R5 enable cleared up", v[0], 0);
            step(); step();
            chk(count == 16'd0, "R5 rests at zero", count, 0);
        end

        // R6 / R12: periodic down L=3 P=0, timeouts at edges 4, 8, 12
        prep(16'd3, 16'd0, 16'd3);
        wr(3'd0, 16'h0005);
        repeat (4) step();
        rd(3'd7, v); chk(v[0] == 1'b1, "R6 first timeout", v[0], 1);
        repeat (3) step();
        wr(3'd6, 16'h0001);
        rd(3'd7, v); chk(v[0] == 1'b1, "R12 set wins over clear", v[0], 1);
        wr(3'd6, 16'h0001);
        rd(3'd7, v); chk(v[0] == 1'b0, "R12 clear", v[0], 0);
        rd(3'd0, v); chk(v[0] == 1'b1, "R6 still enabled", v[0], 1);
        repeat (3) step();
        rd(3'd7, v); chk(v[0] == 1'b1, "R6 later timeout", v[0], 1);
        chk(count == 16'd3, "R6 reloaded", count, 3);
        wr(3'd0, 16'h0);

        // R8: pause between prescaler ticks, total 12 cycles, 4 used
        prep(16'd3, 16'd2, 16'd3);
        wr(3'd0, 16'h0003);
        repeat (3) step();
        wr(3'd0, 16'h0002);
        chk(count == 16'd2, "R8 count at pause", count, 2);
        repeat (10) step();
        chk(count == 16'd2, "R8 count held", count, 2);
        rd(3'd7, v); chk(v[0] == 1'b0, "R8 no timeout while off", v[0], 0);
        wr(3'd0, 16'h0003);
        measure(0, 100, n);
        chk(n == 8, "R8 phase held", n, 8);

        // R7: idle modes 00 and 11 do not count
        prep(16'd5, 16'd0, 16'd9);
        wr(3'd0, 16'h0001);
        repeat (10) step();
        chk(count == 16'd9, "R7 mode 00 idle", count, 9);
        wr(3'd0, 16'h0007);
        repeat (10) step();
        chk(count == 16'd9, "R7 mode 11 idle", count, 9);
        rd(3'd7, v); chk(v == 16'h0, "R7 no flags", v, 0);

        // R10 / R11 / R12: match flag, mask, irq and clear
        prep(16'd20, 16'd0, 16'd0);
        wr(3'd5, 16'h0000);
        wr(3'd3, 16'd7);
        wr(3'd0, 16'h000D);
        measure(4, 100, n);
        chk(n == 8, "R10 match timing", n, 8);
        chk(irq == 1'b0, "R11 masked off irq low", irq, 0);
        rd(3'd6, v); chk(v == 16'h0, "R11 masked read zero", v, 0);
        wr(3'd5, 16'h0010);
        chk(irq == 1'b1, "R11 irq with mask", irq, 1);
        rd(3'd6, v); chk(v == 16'h0010, "R11 masked read", v, 16'h10);
        wr(3'd0, 16'h0);
        wr(3'd6, 16'h0010);
        rd(3'd7, v); chk(v[4] == 1'b0, "R12 match cleared", v[4], 0);
        chk(irq == 1'b0, "R12 irq drops", irq, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule